// File: doc/BRIEF.md
# TLB Entry Management Register Front End

This block gives software register-level control over a small translation lookaside buffer. Through a narrow register bus (register number, write data, read data and an extended-half select), software picks an entry with an index register and reads or writes that entry's tag word and its 64-bit data word. A process identifier register and a zone protection register hold the context used by translation. A write-only search register runs an associative lookup over all entries and returns the winning entry number in the index register, or raises a miss flag there.

Moving the tag word also moves the entry's translation identifier. A tag write stamps the entry with the current process identifier. A tag read copies the entry's identifier back into the process identifier register. A configuration level input decides which registers software may touch. The search takes one extra cycle, and a busy output covers that cycle.

Register numbers on `bus_reg` are 0 data word, 1 tag word, 2 process identifier, 3 zone protection, 4 index, 5 search. Numbers 6 and 7 are undefined.

Top module: `tlb_regif`

## Requirements
- R1: After reset, the index, process identifier and zone registers, every tag and data word, and every translation identifier are zero, and `search_busy` is low.
- R2: A write to register 4 (index) updates bits [30:0] only. Bit 31 is the miss flag, which the bus cannot write. A read of register 4 returns all 32 bits.
- R3: Registers 0 and 1 act on the entry numbered by index bits [7:0]. If that number is NUM_ENTRIES or larger, writes to these registers are ignored and reads of them return zero.
- R4: With `bus_ext`=0, register 0 reaches bits [31:0] of the entry's 64-bit data word. With `bus_ext`=1 it reaches bits [63:32]. Any access with `bus_ext`=1 to a register other than 0 is ignored, and such a read returns zero.
- R5: A write to register 1 stores the low 8 bits of the process identifier as that entry's translation identifier. A read of register 1 copies that identifier into the process identifier register, which reads back as the identifier zero-extended.
- R6: The search compares the written address with bits [9:0] cleared. An entry matches only if all of the following hold. Its tag bit 6 (valid) is set. Its tag and the address agree above the page size, which is 1 KiB times 4 to the power of tag bits [9:7]. Its identifier is zero or equals the process identifier. It is not blocked by its zone. The zone number is data bits [7:4]. Zone z owns zone register bits [31-2z:30-2z]. Code 00 blocks the entry while `user_mode` is 1. When several entries match, the lowest-numbered entry wins.
- R7: On a search hit, the index register becomes the matched entry number with every other bit zero, which clears the miss flag. On a miss, bit 31 is set and bits [30:0] are kept.
- R8: `search_busy` is high for exactly the one cycle after an accepted write to register 5. The result is written at the clock edge that ends that cycle. A search write during that cycle is ignored. The result overrides an index write made at the same edge.
- R9: Register 5 is write-only. A read of it returns zero.
- R10: Level input `cfg_level` works as follows. At 0, every access is ignored and every read returns zero. At 1, writes to registers 2, 3 and 5 are ignored, and all other accesses work. At 2 or 3, every access works.
- R11: Register numbers 6 and 7 read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_level | input | 2 | Access level: 0 none, 1 read-mostly, 2 or 3 full |
| user_mode | input | 1 | 1 when the current access mode is unprivileged |
| bus_en | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_ext | input | 1 | Selects the upper half of the data word |
| bus_reg | input | 3 | Register number |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| search_busy | output | 1 | Search lookup pending |

## Verification
Read data is combinational, so the bench samples it in the access cycle, a couple of nanoseconds after driving on the falling edge. Register writes, identifier moves and gating take effect at the next rising edge. The bench confirms these with a read in a later cycle. A search write raises `search_busy` at the first rising edge. The bench checks this just after that edge, then checks that busy has dropped one edge later. Only then does it read the index result. The ignored-during-busy and override cases drive their second write exactly into that single busy cycle.

// File: rtl/tlb_regif_pkg.sv
package tlb_regif_pkg;
   localparam logic [2:0] REG_DATA   = 3'd0;
   localparam logic [2:0] REG_TAG    = 3'd1;
   localparam logic [2:0] REG_PID    = 3'd2;
   localparam logic [2:0] REG_ZONE   = 3'd3;
   localparam logic [2:0] REG_INDEX  = 3'd4;
   localparam logic [2:0] REG_SEARCH = 3'd5;

   localparam logic [1:0] LVL_NONE   = 2'd0;

   localparam int TAG_VALID_BIT = 6;
   localparam int TAG_SIZE_LSB  = 7;
   localparam int DATA_ZONE_LSB = 4;
   localparam logic [31:0] PAGE_ADDR_MASK = 32'hFFFF_FC00;
   localparam logic [31:0] MISS_FLAG      = 32'h8000_0000;

   // keep-mask of address bits that must agree for a page of size code f
   function automatic logic [31:0] page_keep_mask(input logic [2:0] f);
      logic [31:0] span;
      span = 32'd1024 << {f, 1'b0};
      return ~(span - 32'd1);
   endfunction
endpackage

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
   import tlb_regif_pkg::*;
#(
   parameter int TID_W     = 8,
   parameter int NUM_ZONES = 16
) (
   input  logic [31:0]      tag,
   input  logic [3:0]       zsel,
   input  logic [TID_W-1:0] tid,
   input  logic [TID_W-1:0] pid,
   input  logic [31:0]      zone_reg,
   input  logic             user,
   input  logic [31:0]      va,
   output logic             hit
);
   logic [4:0]  shamt;
   logic [1:0]  zcode;
   logic        zone_live;
   logic        blocked;
   logic        page_eq;
   logic        tid_ok;

   always_comb begin
      shamt     = 5'd30 - {zsel, 1'b0};
      zcode     = 2'((zone_reg >> shamt) & 32'h3);
      zone_live = (32'(zsel) < 32'(NUM_ZONES));
      blocked   = user && zone_live && (zcode == 2'b00);
      page_eq   = (((va ^ tag) & page_keep_mask(tag[TAG_SIZE_LSB +: 3])) == 32'd0);
      tid_ok    = (tid == '0) || (tid == pid);
      hit       = tag[TAG_VALID_BIT] && page_eq && tid_ok && !blocked;
   end
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
   parameter int N  = 16,
   parameter int IW = 4
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
   import tlb_regif_pkg::*;
#(
   parameter int N         = 16,
   parameter int IW        = 4,
   parameter int TID_W     = 8,
   parameter int NUM_ZONES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    sel,
   input  logic             wr_tag,
   input  logic             wr_dlo,
   input  logic             wr_dhi,
   input  logic [31:0]      wdata,
   input  logic [TID_W-1:0] wtid,
   output logic [31:0]      rd_tag,
   output logic [31:0]      rd_dlo,
   output logic [31:0]      rd_dhi,
   output logic [TID_W-1:0] rd_tid,
   input  logic [31:0]      lk_va,
   input  logic [TID_W-1:0] lk_pid,
   input  logic [31:0]      lk_zone,
   input  logic             lk_user,
   output logic [N-1:0]     lk_hits
);
   logic [31:0]      tag_q [N];
   logic [31:0]      dlo_q [N];
   logic [31:0]      dhi_q [N];
   logic [TID_W-1:0] tid_q [N];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            tag_q[i] <= '0;
            dlo_q[i] <= '0;
            dhi_q[i] <= '0;
            tid_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < N; i++) begin
            if (sel == IW'(i)) begin
               if (wr_tag) begin
                  tag_q[i] <= wdata;
                  tid_q[i] <= wtid;
               end
               if (wr_dlo) dlo_q[i] <= wdata;
               if (wr_dhi) dhi_q[i] <= wdata;
            end
         end
      end
   end

   always_comb begin
      rd_tag = '0;
      rd_dlo = '0;
      rd_dhi = '0;
      rd_tid = '0;
      for (int i = 0; i < N; i++) begin
         if (sel == IW'(i)) begin
            rd_tag = tag_q[i];
            rd_dlo = dlo_q[i];
            rd_dhi = dhi_q[i];
            rd_tid = tid_q[i];
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_cell
      tlb_match_cell #(
         .TID_W     (TID_W),
         .NUM_ZONES (NUM_ZONES)
      ) u_cell (
         .tag      (tag_q[g]),
         .zsel     (dlo_q[g][DATA_ZONE_LSB +: 4]),
         .tid      (tid_q[g]),
         .pid      (lk_pid),
         .zone_reg (lk_zone),
         .user     (lk_user),
         .va       (lk_va),
         .hit      (lk_hits[g])
      );
   end
endmodule

// File: rtl/tlb_regif.sv
module tlb_regif
   import tlb_regif_pkg::*;
#(
   parameter int NUM_ENTRIES = 16,
   parameter int NUM_ZONES   = 16,
   parameter int TID_W       = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  cfg_level,
   input  logic        user_mode,
   input  logic        bus_en,
   input  logic        bus_we,
   input  logic        bus_ext,
   input  logic [2:0]  bus_reg,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        search_busy
);
   localparam int IW = $clog2(NUM_ENTRIES);

   if (NUM_ENTRIES < 2 || NUM_ENTRIES > 256) begin : g_bad_entries
      $error("NUM_ENTRIES must lie in 2..256");
   end
   if (NUM_ZONES < 1 || NUM_ZONES > 16) begin : g_bad_zones
      $error("NUM_ZONES must lie in 1..16");
   end
   if (TID_W < 1 || TID_W > 8) begin : g_bad_tid
      $error("TID_W must lie in 1..8");
   end

   logic [31:0]      index_q;
   logic [TID_W-1:0] pid_q;
   logic [31:0]      zone_q;
   logic             busy_q;
   logic [31:0]      va_q;

   logic [7:0]       ent_sel;
   logic             in_range;
   logic             lvl_full;
   logic             legal, do_rd, do_wr;
   logic             wr_tag, wr_dlo, wr_dhi, rd_tag_ev, srch_go;
   logic [31:0]      rd_tag, rd_dlo, rd_dhi;
   logic [TID_W-1:0] rd_tid;
   logic [NUM_ENTRIES-1:0] lk_hits;
   logic             pick_found;
   logic [IW-1:0]    pick_idx;

   always_comb begin
      ent_sel   = index_q[7:0];
      in_range  = (32'(ent_sel) < 32'(NUM_ENTRIES));
      lvl_full  = cfg_level[1];
      legal     = bus_en && (cfg_level != LVL_NONE) && (!bus_ext || bus_reg == REG_DATA);
      do_rd     = legal && !bus_we;
      do_wr     = legal && bus_we;
      wr_tag    = do_wr && in_range && (bus_reg == REG_TAG);
      wr_dlo    = do_wr && in_range && (bus_reg == REG_DATA) && !bus_ext;
      wr_dhi    = do_wr && in_range && (bus_reg == REG_DATA) && bus_ext;
      rd_tag_ev = do_rd && in_range && (bus_reg == REG_TAG);
      srch_go   = do_wr && lvl_full && (bus_reg == REG_SEARCH) && !busy_q;
   end

   tlb_entry_store #(
      .N         (NUM_ENTRIES),
      .IW        (IW),
      .TID_W     (TID_W),
      .NUM_ZONES (NUM_ZONES)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (ent_sel[IW-1:0]),
      .wr_tag  (wr_tag),
      .wr_dlo  (wr_dlo),
      .wr_dhi  (wr_dhi),
      .wdata   (bus_wdata),
      .wtid    (pid_q),
      .rd_tag  (rd_tag),
      .rd_dlo  (rd_dlo),
      .rd_dhi  (rd_dhi),
      .rd_tid  (rd_tid),
      .lk_va   (va_q),
      .lk_pid  (pid_q),
      .lk_zone (zone_q),
      .lk_user (user_mode),
      .lk_hits (lk_hits)
   );

   tlb_prio_pick #(
      .N  (NUM_ENTRIES),
      .IW (IW)
   ) u_pick (
      .req   (lk_hits),
      .found (pick_found),
      .idx   (pick_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= '0;
         pid_q   <= '0;
         zone_q  <= '0;
         busy_q  <= 1'b0;
         va_q    <= '0;
      end else begin
         busy_q <= srch_go;
         if (srch_go) va_q <= bus_wdata & PAGE_ADDR_MASK;

         if (busy_q) begin
            index_q <= pick_found ? 32'(pick_idx) : (index_q | MISS_FLAG);
         end else if (do_wr && bus_reg == REG_INDEX) begin
            index_q[30:0] <= bus_wdata[30:0];
         end

         if (do_wr && lvl_full && bus_reg == REG_PID) begin
            pid_q <= bus_wdata[TID_W-1:0];
         end else if (rd_tag_ev) begin
            pid_q <= rd_tid;
         end

         if (do_wr && lvl_full && bus_reg == REG_ZONE) zone_q <= bus_wdata;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (do_rd) begin
         case (bus_reg)
            REG_DATA:  if (in_range) bus_rdata = bus_ext ? rd_dhi : rd_dlo;
            REG_TAG:   if (in_range) bus_rdata = rd_tag;
            REG_PID:   bus_rdata = 32'(pid_q);
            REG_ZONE:  bus_rdata = zone_q;
            REG_INDEX: bus_rdata = index_q;
            default:   bus_rdata = '0;
         endcase
      end
   end

   assign search_busy = busy_q;
endmodule

// File: rtl/tlb_regif_chk.sv
module tlb_regif_chk #(
   parameter int PID_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cfg_level,
   input logic             bus_en,
   input logic             bus_we,
   input logic             bus_ext,
   input logic [2:0]       bus_reg,
   input logic [31:0]      bus_rdata,
   input logic             search_busy,
   input logic [31:0]      index_q,
   input logic [PID_W-1:0] pid_q
);
   // R8
   busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      search_busy |=> !search_busy);

   // R2
   miss_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !search_busy |=> $stable(index_q[31]));

   // R9
   search_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_reg == 3'd5) |-> (bus_rdata == 32'd0));

   // R4
   ext_other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_ext && bus_reg != 3'd0) |-> (bus_rdata == 32'd0));

   // R10
   pid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && cfg_level < 2'd2 && bus_reg == 3'd2) |=> $stable(pid_q));

   // R10
   no_access_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && cfg_level == 2'd0) |-> (bus_rdata == 32'd0));

   // R11
   undef_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_reg[2:1] == 2'b11) |-> (bus_rdata == 32'd0));
endmodule

bind tlb_regif tlb_regif_chk #(.PID_W(TID_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_level   (cfg_level),
   .bus_en      (bus_en),
   .bus_we      (bus_we),
   .bus_ext     (bus_ext),
   .bus_reg     (bus_reg),
   .bus_rdata   (bus_rdata),
   .search_busy (search_busy),
   .index_q     (index_q),
   .pid_q       (pid_q)
);

// File: tb/sim_tlb_regif.sv
module sim_tlb_regif;
   localparam logic [2:0] A_DATA = 3'd0, A_TAG = 3'd1, A_PID = 3'd2, A_ZONE = 3'd3,
                          A_IDX = 3'd4, A_SRCH = 3'd5;
   localparam logic [31:0] V = 32'h40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_level = 2'd3;
   logic        user_mode = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0, bus_ext = 1'b0;
   logic [2:0]  bus_reg = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        search_busy;

   always #10 clk = ~clk;

   tlb_regif u0 (
      .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .user_mode(user_mode),
      .bus_en(bus_en), .bus_we(bus_we), .bus_ext(bus_ext), .bus_reg(bus_reg),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .search_busy(search_busy)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic reset_dut();
      cfg_level = 2'd3; user_mode = 1'b0;
      bus_en = 0; bus_we = 0; bus_ext = 0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input logic [2:0] r, input logic [31:0] d, input logic x);
      @(negedge clk);
      bus_en = 1; bus_we = 1; bus_reg = r; bus_wdata = d; bus_ext = x;
      @(posedge clk); #1;
      bus_en = 0; bus_we = 0; bus_ext = 0;
   endtask

   task automatic rd(input logic [2:0] r, input logic x, output logic [31:0] d);
      @(negedge clk);
      bus_en = 1; bus_we = 0; bus_reg = r; bus_ext = x;
      #2 d = bus_rdata;
      @(posedge clk); #1;
      bus_en = 0; bus_ext = 0;
   endtask

   task automatic expect_rd(input string req, input logic [2:0] r, input logic x,
                            input logic [31:0] exp);
      logic [31:0] v;
      rd(r, x, v);
      chk(req, v, exp);
   endtask

   task automatic search(input string req, input logic [31:0] va, input logic [31:0] exp_idx);
      wr(A_SRCH, va, 0);
      chk({req, " busy up"}, 32'(search_busy), 32'd1);
      @(posedge clk); #1;
      chk({req, " busy down"}, 32'(search_busy), 32'd0);
      expect_rd(req, A_IDX, 0, exp_idx);
   endtask

   task automatic t_reset();
      reset_dut();
      chk("R1 busy", 32'(search_busy), 32'd0);
      expect_rd("R1 index", A_IDX, 0, 32'd0);
      expect_rd("R1 pid", A_PID, 0, 32'd0);
      expect_rd("R1 zone", A_ZONE, 0, 32'd0);
      expect_rd("R1 tag", A_TAG, 0, 32'd0);
      expect_rd("R1 data hi", A_DATA, 1, 32'd0);
   endtask

   task automatic t_index();
      reset_dut();
      wr(A_IDX, 32'hFFFF_FFFF, 0);
      expect_rd("R2 bit31 read-only", A_IDX, 0, 32'h7FFF_FFFF);
   endtask

   task automatic t_range();
      reset_dut();
      wr(A_IDX, 32'd20, 0);
      wr(A_TAG, 32'h1234_5678, 0);
      wr(A_DATA, 32'hCAFE_0000, 0);
      expect_rd("R3 out-of-range tag", A_TAG, 0, 32'd0);
      wr(A_IDX, 32'd4, 0);
      expect_rd("R3 no alias tag", A_TAG, 0, 32'd0);
      expect_rd("R3 no alias data", A_DATA, 0, 32'd0);
      wr(A_TAG, 32'h0ABC_0000, 0);
      expect_rd("R3 in-range tag", A_TAG, 0, 32'h0ABC_0000);
   endtask

   task automatic t_halves();
      reset_dut();
      wr(A_IDX, 32'd3, 0);
      wr(A_DATA, 32'hA5A5_0000, 0);
      wr(A_DATA, 32'h1111_2222, 1);
      expect_rd("R4 low half", A_DATA, 0, 32'hA5A5_0000);
      expect_rd("R4 high half", A_DATA, 1, 32'h1111_2222);
      wr(A_TAG, 32'hDEAD_0000, 1);
      expect_rd("R4 ext tag write ignored", A_TAG, 0, 32'd0);
      wr(A_IDX, 32'd9, 1);
      expect_rd("R4 ext index write ignored", A_IDX, 0, 32'd3);
      expect_rd("R4 ext index read zero", A_IDX, 1, 32'd0);
   endtask

   task automatic t_tid();
      reset_dut();
      wr(A_PID, 32'h5A, 0);
      wr(A_IDX, 32'd2, 0);
      wr(A_TAG, 32'h0010_0000, 0);
      wr(A_PID, 32'h00, 0);
      expect_rd("R5 tag read data", A_TAG, 0, 32'h0010_0000);
      expect_rd("R5 pid from tid", A_PID, 0, 32'h5A);
   endtask

   task automatic t_search();
      reset_dut();
      wr(A_IDX, 32'd5, 0);  wr(A_TAG, 32'h0080_0000 | V, 0);
      wr(A_IDX, 32'd9, 0);  wr(A_TAG, 32'h0080_0000 | V, 0);
      wr(A_IDX, 32'd2, 0);  wr(A_TAG, 32'h0040_0000 | V | 32'h100, 0);
      wr(A_IDX, 32'd7, 0);  wr(A_TAG, 32'h0090_0000, 0);
      wr(A_IDX, 32'h1234_0000, 0);
      search("R7 hit clears other bits, R6 lowest wins", 32'h0080_0000, 32'd5);
      search("R6 16K page covers offset", 32'h0040_2C00, 32'd2);
      search("R7 miss keeps bits", 32'h0040_4000, 32'h8000_0002);
      search("R7 hit clears miss", 32'h0080_03FF, 32'd5);
      search("R6 invalid entry skipped", 32'h0090_0000, 32'h8000_0005);
   endtask

   task automatic t_tidmatch();
      reset_dut();
      wr(A_PID, 32'h33, 0);
      wr(A_IDX, 32'd1, 0); wr(A_TAG, 32'h0100_0000 | V, 0);
      wr(A_PID, 32'h00, 0);
      wr(A_IDX, 32'd6, 0); wr(A_TAG, 32'h0200_0000 | V, 0);
      wr(A_PID, 32'h44, 0);
      wr(A_IDX, 32'd0, 0);
      search("R6 tid mismatch", 32'h0100_0000, 32'h8000_0000);
      wr(A_PID, 32'h33, 0);
      search("R6 tid match", 32'h0100_0000, 32'd1);
      wr(A_PID, 32'h44, 0);
      search("R6 global tid", 32'h0200_0000, 32'd6);
   endtask

   task automatic t_zone();
      reset_dut();
      wr(A_IDX, 32'd0, 0);
      wr(A_TAG, 32'h0300_0000 | V, 0);
      wr(A_DATA, 32'h0000_0030, 0);
      user_mode = 1'b1;
      search("R6 zone 00 blocks user", 32'h0300_0000, 32'h8000_0000);
      user_mode = 1'b0;
      search("R6 zone 00 privileged ok", 32'h0300_0000, 32'd0);
      wr(A_ZONE, 32'h0100_0000, 0);
      wr(A_IDX, 32'h55, 0);
      user_mode = 1'b1;
      search("R6 zone 01 user ok", 32'h0300_0000, 32'd0);
      user_mode = 1'b0;
   endtask

   task automatic t_busy();
      reset_dut();
      wr(A_IDX, 32'd4, 0);
      wr(A_TAG, 32'h0500_0000 | V, 0);
      wr(A_SRCH, 32'h0500_0000, 0);
      chk("R8 busy after search", 32'(search_busy), 32'd1);
      wr(A_SRCH, 32'h0600_0000, 0);
      chk("R8 second search ignored", 32'(search_busy), 32'd0);
      expect_rd("R8 first result kept", A_IDX, 0, 32'd4);
      wr(A_SRCH, 32'h0600_0000, 0);
      wr(A_IDX, 32'h77, 0);
      expect_rd("R8 result overrides index write", A_IDX, 0, 32'h8000_0004);
   endtask

   task automatic t_level();
      reset_dut();
      cfg_level = 2'd1;
      wr(A_PID, 32'h12, 0);
      expect_rd("R10 pid write blocked", A_PID, 0, 32'd0);
      wr(A_ZONE, 32'hFFFF_0000, 0);
      expect_rd("R10 zone write blocked", A_ZONE, 0, 32'd0);
      wr(A_IDX, 32'd3, 0);
      expect_rd("R10 index write allowed", A_IDX, 0, 32'd3);
      wr(A_TAG, 32'h0700_0000 | V, 0);
      expect_rd("R10 tag write allowed", A_TAG, 0, 32'h0700_0040);
      wr(A_SRCH, 32'h0700_0000, 0);
      chk("R10 search blocked busy", 32'(search_busy), 32'd0);
      @(posedge clk); #1;
      expect_rd("R10 search blocked index", A_IDX, 0, 32'd3);
      cfg_level = 2'd0;
      expect_rd("R10 level0 read zero", A_IDX, 0, 32'd0);
      wr(A_IDX, 32'd9, 0);
      cfg_level = 2'd3;
      expect_rd("R10 level0 write ignored", A_IDX, 0, 32'd3);
   endtask

   task automatic t_undef();
      reset_dut();
      wr(A_ZONE, 32'hABCD_0000, 0);
      expect_rd("R9 search reads zero", A_SRCH, 0, 32'd0);
      expect_rd("R11 reg6 zero", 3'd6, 0, 32'd0);
      expect_rd("R11 reg7 zero", 3'd7, 0, 32'd0);
      wr(3'd6, 32'hFFFF_FFFF, 0);
      wr(3'd7, 32'hFFFF_FFFF, 0);
      expect_rd("R11 index untouched", A_IDX, 0, 32'd0);
      expect_rd("R11 pid untouched", A_PID, 0, 32'd0);
      expect_rd("R11 zone untouched", A_ZONE, 0, 32'hABCD_0000);
   endtask

   initial begin
      t_reset();
      t_index();
      t_range();
      t_halves();
      t_tid();
      t_search();
      t_tidmatch();
      t_zone();
      t_busy();
      t_level();
      t_undef();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule